// File: doc/BRIEF.md
# Multiplexed ADC Channel Scan Sequencer

This block steps an external analog multiplexer through a set of input channels ahead of a sigma-delta converter. The converter has a fourth-order sinc filter. Its serial data line goes low when a conversion is finished. The sequencer synchronises that line into its own clock, which is the serial clock. It turns each falling edge into a single result event. It decides when the multiplexer select may change and counts the conversions that follow each change. For every conversion it reports a keep or discard flag, and for every kept result it reports the channel the result belongs to.

Three switching disciplines are available. In relaxed mode the select changes with no relation to the conversion cycle. Because of that, only the fifth result after the change is kept. In timed mode the select changes a fixed number of serial-clock cycles after a conversion completes. In edge mode it changes when the data line rises again. In both synchronised modes the first result after a switch still belongs to the old channel and is valid. The next three are unsettled, and the one after them is settled for the new channel. The steady rate is therefore one kept result per four conversions. Channels are visited from 0 to N-1 and then wrap back to 0.

The controller has four states:
- `ST_RELAX`: counts results after an unsynchronised switch or after reset.
- `ST_TIMED_WAIT`: runs the switch-delay timer.
- `ST_EDGE_WAIT`: waits for the data line to rise.
- `ST_SETTLE`: counts results after a synchronised switch.

Its transitions are:
- `ST_RELAX` to the mode's arming state when the fifth result arrives. In relaxed mode the next state is `ST_RELAX` again, with an immediate switch.
- `ST_TIMED_WAIT` to `ST_SETTLE` when the timer expires.
- `ST_EDGE_WAIT` to `ST_SETTLE` on a synchronised rising edge.
- `ST_SETTLE` to the mode's arming state on the fourth result after the switch.

Top module: `scan_mux_sequencer`

## Requirements
- R1: A synchronous reset sets `mux_sel` to 0, clears `res_valid` and `res_keep`, and starts relaxed settling. The first kept result after reset is therefore the fifth conversion.
- R2: Each falling edge of `data_rdy_n` yields exactly one result, shown as a single-cycle `res_valid` pulse. The pulse rises on the third rising clock edge after the line is driven low (two synchroniser stages plus one output register).
- R3: In relaxed settling, results one to four are discarded. The fifth is kept with `res_tag` equal to the channel currently selected. In relaxed mode `mux_sel` advances on the same clock edge that raises that kept result.
- R4: In timed mode, once the arming result is reported, `mux_sel` advances exactly SWITCH_DELAY clock edges after the edge that raised its `res_valid`, with a default of 595. A rising edge of `data_rdy_n` has no effect on the select in this mode.
- R5: In edge mode, `mux_sel` holds after the arming result. It advances on the third rising clock edge after `data_rdy_n` is driven high.
- R6: After a synchronised switch, the first result is kept only if the previous channel had completed synchronised settling. When kept, it is tagged with the previous channel; otherwise it is discarded. Results two to four are discarded, and the fourth result arms the next switch.
- R7: Channels advance 0, 1, …, N-1 and then wrap to 0, where N is `cfg_nchan`. N of 0 or 1 keeps the select at 0.
- R8: `res_keep` is only raised together with `res_valid`. At least three discarded results separate any two kept results, so the steady timed-mode rate is one kept result per four conversions.
- R9: `cfg_mode` is encoded as 0 relaxed, 1 timed, 2 edge, and 3 relaxed. It is read at the moment a switch is armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock; all logic is on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| data_rdy_n | input | 1 | Converter serial data line; a falling edge means a conversion is done |
| cfg_mode | input | 2 | Switching discipline: 0 relaxed, 1 timed, 2 edge, 3 relaxed |
| cfg_nchan | input | CH_W+1 | Number of channels in the scan |
| mux_sel | output | CH_W | Analog multiplexer select |
| res_valid | output | 1 | One-cycle strobe per completed conversion |
| res_keep | output | 1 | The current result is settled and should be kept |
| res_tag | output | CH_W | Channel of the kept result (meaningful with `res_keep`) |

## Verification
The bench runs a long timed-mode scan over three channels and compares every conversion's flag, tag and select. This catches designs that keep the duplicate old-channel result after the relaxed start, that miscount the three unsettled results, or that forget to wrap. A directed timed test samples the select one cycle before and exactly at the switch delay, with the data line already high. An off-by-one timer, or a design that switches on the rise, shows up there. Edge-mode and relaxed-mode tests pin the switch to the synchronised rise and to the fifth result. A design with one synchroniser stage too few, or that counts four instead of five, would move the select a cycle early or keep the wrong conversion.

// File: rtl/scan_seq_pkg.sv
package scan_seq_pkg;

    typedef enum logic [1:0] {
        MODE_RELAX = 2'd0,
        MODE_TIMED = 2'd1,
        MODE_EDGE  = 2'd2,
        MODE_ALT   = 2'd3
    } scan_mode_t;

    typedef enum logic [1:0] {
        ST_RELAX      = 2'd0,
        ST_TIMED_WAIT = 2'd1,
        ST_EDGE_WAIT  = 2'd2,
        ST_SETTLE     = 2'd3
    } scan_state_t;

endpackage

// File: rtl/scan_line_sync.sv
module scan_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic line_in,
    output logic fall,
    output logic rise
);
    localparam int LAST = STAGES;

    logic [LAST:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '1;
        end else begin
            chain <= {chain[LAST-1:0], line_in};
        end
    end

    assign fall = chain[LAST] & ~chain[LAST-1];
    assign rise = ~chain[LAST] & chain[LAST-1];

endmodule

// File: rtl/scan_delay_timer.sv
module scan_delay_timer #(
    parameter int DELAY = 595
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic clear,
    output logic done
);
    localparam int TW = $clog2(DELAY + 1);
    localparam logic [TW-1:0] LIMIT = TW'(DELAY);

    logic [TW-1:0] count;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            count <= '0;
        end else if (load) begin
            count <= TW'(1);
        end else if (count != '0 && count != LIMIT) begin
            count <= count + TW'(1);
        end
    end

    assign done = (count == LIMIT);

endmodule

// File: rtl/scan_chan_stepper.sv
module scan_chan_stepper #(
    parameter int CH_W = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            advance,
    input  logic [CH_W:0]   nchan,
    output logic [CH_W-1:0] sel,
    output logic [CH_W-1:0] prev
);
    logic [CH_W:0]   sel_inc;
    logic [CH_W-1:0] sel_next;

    always_comb begin
        sel_inc  = {1'b0, sel} + (CH_W+1)'(1);
        sel_next = (sel_inc >= nchan) ? '0 : sel_inc[CH_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sel  <= '0;
            prev <= '0;
        end else if (advance) begin
            prev <= sel;
            sel  <= sel_next;
        end
    end

endmodule

// File: rtl/scan_mux_sequencer.sv
module scan_mux_sequencer
    import scan_seq_pkg::*;
#(
    parameter int CH_W         = 3,
    parameter int SWITCH_DELAY = 595,
    parameter int SYNC_STAGES  = 2,
    parameter int SETTLE_SYNC  = 4,
    parameter int SETTLE_RELAX = 5
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            data_rdy_n,
    input  logic [1:0]      cfg_mode,
    input  logic [CH_W:0]   cfg_nchan,
    output logic [CH_W-1:0] mux_sel,
    output logic            res_valid,
    output logic            res_keep,
    output logic [CH_W-1:0] res_tag
);
    localparam int CNT_W = $clog2(SETTLE_RELAX + 1);
    localparam logic [CNT_W-1:0] RELAX_LAST = CNT_W'(SETTLE_RELAX - 1);
    localparam logic [CNT_W-1:0] SYNC_LAST  = CNT_W'(SETTLE_SYNC - 1);

    logic ev_fall, ev_rise, t_done;
    logic adv, t_load, t_clear;
    logic [CH_W-1:0] prev_sel;

    scan_state_t state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic carry_q, carry_d;

    scan_state_t arm_state;
    logic arm_load, arm_adv;

    logic o_valid, o_keep;
    logic [CH_W-1:0] o_tag;

    scan_line_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk(clk), .rst(rst), .line_in(data_rdy_n),
        .fall(ev_fall), .rise(ev_rise)
    );

    scan_delay_timer #(.DELAY(SWITCH_DELAY)) i_timer (
        .clk(clk), .rst(rst), .load(t_load), .clear(t_clear), .done(t_done)
    );

    scan_chan_stepper #(.CH_W(CH_W)) i_step (
        .clk(clk), .rst(rst), .advance(adv), .nchan(cfg_nchan),
        .sel(mux_sel), .prev(prev_sel)
    );

    // where an armed switch goes, chosen from the mode at arming time
    always_comb begin
        arm_state = ST_RELAX;
        arm_load  = 1'b0;
        arm_adv   = 1'b0;
        unique case (scan_mode_t'(cfg_mode))
            MODE_TIMED: begin
                arm_state = ST_TIMED_WAIT;
                arm_load  = 1'b1;
            end
            MODE_EDGE: begin
                arm_state = ST_EDGE_WAIT;
            end
            MODE_RELAX, MODE_ALT: begin
                arm_state = ST_RELAX;
                arm_adv   = 1'b1;
            end
            default: begin
                arm_state = ST_RELAX;
                arm_adv   = 1'b1;
            end
        endcase
    end

    // next state and per-result decision
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        carry_d = carry_q;
        adv     = 1'b0;
        t_load  = 1'b0;
        t_clear = 1'b0;
        o_valid = ev_fall;
        o_keep  = 1'b0;
        o_tag   = mux_sel;
        unique case (state_q)
            ST_RELAX: begin
                if (ev_fall) begin
                    if (cnt_q == RELAX_LAST) begin
                        o_keep  = 1'b1;
                        o_tag   = mux_sel;
                        carry_d = 1'b0;
                        cnt_d   = '0;
                        state_d = arm_state;
                        t_load  = arm_load;
                        adv     = arm_adv;
                    end else begin
                        cnt_d = cnt_q + CNT_W'(1);
                    end
                end
            end
            ST_TIMED_WAIT: begin
                if (t_done) begin
                    adv     = 1'b1;
                    t_clear = 1'b1;
                    cnt_d   = '0;
                    state_d = ST_SETTLE;
                end
            end
            ST_EDGE_WAIT: begin
                if (ev_rise) begin
                    adv     = 1'b1;
                    cnt_d   = '0;
                    state_d = ST_SETTLE;
                end
            end
            ST_SETTLE: begin
                if (ev_fall) begin
                    if (cnt_q == '0) begin
                        o_keep = carry_q;
                        o_tag  = prev_sel;
                    end
                    if (cnt_q == SYNC_LAST) begin
                        carry_d = 1'b1;
                        cnt_d   = '0;
                        state_d = arm_state;
                        t_load  = arm_load;
                        adv     = arm_adv;
                    end else begin
                        cnt_d = cnt_q + CNT_W'(1);
                    end
                end
            end
            default: begin
                state_d = ST_RELAX;
                cnt_d   = '0;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_RELAX;
            cnt_q   <= '0;
            carry_q <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            carry_q <= carry_d;
        end
    end

    // output register
    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid <= 1'b0;
            res_keep  <= 1'b0;
            res_tag   <= '0;
        end else begin
            res_valid <= o_valid;
            res_keep  <= o_valid & o_keep;
            res_tag   <= o_tag;
        end
    end

endmodule

// File: rtl/scan_seq_checker.sv
module scan_seq_checker #(
    parameter int CH_W = 3
) (
    input logic            clk,
    input logic            rst,
    input logic [CH_W-1:0] mux_sel,
    input logic            res_valid,
    input logic            res_keep
);
    logic [2:0] since_keep;
    logic       kept_any;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_keep <= '0;
            kept_any   <= 1'b0;
        end else if (res_valid) begin
            if (res_keep) begin
                since_keep <= '0;
                kept_any   <= 1'b1;
            end else if (since_keep != 3'd7) begin
                since_keep <= since_keep + 3'd1;
            end
        end
    end

    AST_RESET_STATE: assert property (@(posedge clk) $past(rst) |-> (mux_sel == '0 && !res_valid && !res_keep)); // R1
    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst) res_valid |=> !res_valid); // R2
    AST_KEEP_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst) res_keep |-> res_valid); // R8
    AST_KEEP_SPACING: assert property (@(posedge clk) disable iff (rst) (res_keep && kept_any) |-> since_keep >= 3'd3); // R8
    AST_FIRST_KEEP: assert property (@(posedge clk) disable iff (rst) (res_keep && !kept_any) |-> since_keep >= 3'd4); // R1
    AST_SEL_STEP: assert property (@(posedge clk) disable iff (rst) (mux_sel != $past(mux_sel)) |-> (mux_sel == '0 || mux_sel == CH_W'($past(mux_sel) + 1'b1))); // R7

endmodule

bind scan_mux_sequencer scan_seq_checker #(.CH_W(CH_W)) i_chk (
    .clk(clk), .rst(rst), .mux_sel(mux_sel), .res_valid(res_valid), .res_keep(res_keep)
);

// File: tb/test_scan_mux_sequencer.sv
module test_scan_mux_sequencer;
    localparam int CLK_PERIOD = 10;
    localparam int CH_W = 3;
    localparam int DLY = 595;
    localparam int WATCHDOG = 150000;
    localparam int NVEC = 18;
    // vector bits: [7] keep, [6:4] tag, [2:0] select after the conversion
    localparam logic [7:0] VEC [NVEC] = '{
        8'h00, 8'h00, 8'h00, 8'h00, 8'h81, 8'h01, 8'h01, 8'h01, 8'h02,
        8'h92, 8'h02, 8'h02, 8'h00, 8'hA0, 8'h00, 8'h00, 8'h01, 8'h81
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic data_rdy_n = 1'b1;
    logic [1:0] cfg_mode = 2'd0;
    logic [CH_W:0] cfg_nchan = 4'd3;
    logic [CH_W-1:0] mux_sel, res_tag;
    logic res_valid, res_keep;
    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    scan_mux_sequencer #(.CH_W(CH_W), .SWITCH_DELAY(DLY)) i_scan_mux_sequencer (
        .clk(clk), .rst(rst), .data_rdy_n(data_rdy_n), .cfg_mode(cfg_mode),
        .cfg_nchan(cfg_nchan), .mux_sel(mux_sel), .res_valid(res_valid),
        .res_keep(res_keep), .res_tag(res_tag)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > WATCHDOG) begin
            errors = errors + 1;
            $display("FAIL watchdog act=%0d exp=%0d", cycles, WATCHDOG);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset(input logic [1:0] mode, input int n);
        @(negedge clk);
        rst = 1'b1;
        data_rdy_n = 1'b1;
        cfg_mode = mode;
        cfg_nchan = (CH_W+1)'(n);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    // drive the line low and check the result reported three edges later
    task automatic fall_chk(input string req, input logic keep, input int tag);
        @(negedge clk);
        data_rdy_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R2", "res_valid", int'(res_valid), 1);
        chk(req, "res_keep", int'(res_keep), int'(keep));
        if (keep) chk(req, "res_tag", int'(res_tag), tag);
    endtask

    task automatic rise_idle(input int n);
        @(negedge clk);
        data_rdy_n = 1'b1;
        repeat (n) @(negedge clk);
    endtask

    initial begin
        // R1: reset state
        do_reset(2'd1, 3);
        chk("R1", "mux_sel", int'(mux_sel), 0);
        chk("R1", "res_valid", int'(res_valid), 0);
        chk("R1", "res_keep", int'(res_keep), 0);

        // R6 R8 R7: table-driven timed scan over three channels
        for (int i = 0; i < NVEC; i++) begin
            fall_chk("R6", VEC[i][7], int'(VEC[i][6:4]));
            @(negedge clk);
            chk("R2", "res_valid one cycle", int'(res_valid), 0);
            rise_idle(700);
            chk("R7", "mux_sel after conversion", int'(mux_sel), int'(VEC[i][2:0]));
        end

        // R4: exact switch delay, rising edge ignored
        do_reset(2'd1, 2);
        for (int i = 0; i < 4; i++) begin
            fall_chk("R1", 1'b0, 0);
            rise_idle(700);
        end
        fall_chk("R3", 1'b1, 0);
        data_rdy_n = 1'b1;
        repeat (DLY - 1) @(posedge clk);
        @(negedge clk);
        chk("R4", "mux_sel before delay", int'(mux_sel), 0);
        @(posedge clk);
        @(negedge clk);
        chk("R4", "mux_sel at delay", int'(mux_sel), 1);

        // R5: edge mode switches on the synchronised rise
        do_reset(2'd2, 4);
        for (int i = 0; i < 4; i++) begin
            fall_chk("R3", 1'b0, 0);
            rise_idle(700);
        end
        fall_chk("R3", 1'b1, 0);
        repeat (DLY + 50) @(negedge clk);
        chk("R5", "mux_sel while low", int'(mux_sel), 0);
        data_rdy_n = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R5", "mux_sel two edges after rise", int'(mux_sel), 0);
        @(posedge clk);
        @(negedge clk);
        chk("R5", "mux_sel three edges after rise", int'(mux_sel), 1);
        rise_idle(20);
        fall_chk("R6", 1'b0, 0);
        rise_idle(700);

        // R3: relaxed mode keeps every fifth result and switches at once
        do_reset(2'd0, 3);
        for (int i = 0; i < 4; i++) begin
            fall_chk("R3", 1'b0, 0);
            rise_idle(700);
        end
        fall_chk("R3", 1'b1, 0);
        chk("R3", "mux_sel with keep", int'(mux_sel), 1);
        rise_idle(700);
        for (int i = 0; i < 4; i++) begin
            fall_chk("R3", 1'b0, 0);
            rise_idle(700);
        end
        fall_chk("R3", 1'b1, 1);
        chk("R3", "mux_sel with second keep", int'(mux_sel), 2);
        rise_idle(100);

        // R9: mode 3 behaves as relaxed
        do_reset(2'd3, 2);
        for (int i = 0; i < 4; i++) begin
            fall_chk("R9", 1'b0, 0);
            rise_idle(100);
        end
        fall_chk("R9", 1'b1, 0);
        chk("R9", "mux_sel mode 3", int'(mux_sel), 1);
        rise_idle(100);

        // R7: single channel holds select at 0
        do_reset(2'd0, 1);
        for (int i = 0; i < 4; i++) begin
            fall_chk("R7", 1'b0, 0);
            rise_idle(100);
        end
        fall_chk("R7", 1'b1, 0);
        chk("R7", "mux_sel one channel", int'(mux_sel), 0);
        rise_idle(100);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule